// File: doc/BRIEF.md
# In-Order Bundle Packer with One-Deep Deferral

This block turns a stream of scalar operations into wide issue bundles for a machine with several parallel execution slots. Each incoming operation has an identifier. It may also name one earlier operation whose result it consumes. The packer fills the slots of the open bundle in arrival order. A consumer must never sit in the same bundle as its producer.

When an operation conflicts with the open bundle, the packer does not close the bundle at once. It sets that operation aside in a single holding register and keeps filling the open bundle with later independent operations. The held operation then opens the next bundle in slot 0. So no operation moves more than one bundle away from where strict order would put it. A bundle is emitted when all its slots are full, when a second conflict arrives that cannot be held, or when the stream is flushed. Empty slots go out as no-ops.

Both sides use valid/ready handshakes. The bundle output register holds its contents while the consumer stalls, so nothing is lost or reordered.

Top module: `vliw_packer`

## Requirements
- R1: A bundle holds at most SLOTS operations. Operations fill slots 0, 1, 2, ... in the order they are placed, so in every emitted bundle the set bits of `out_slot_valid` form a contiguous run starting at bit 0. Slot i's id is `out_slot_id[i*ID_W +: ID_W]`.
- R2: An operation with `in_dep_valid`=1 is never emitted in the same bundle as the operation whose id equals `in_dep_id`. When `in_dep_valid`=0, `in_dep_id` is ignored.
- R3: An operation whose producer was emitted in an earlier bundle is placed in the open bundle like an independent one.
- R4: An operation whose producer is in the open bundle is held while no other operation is held. Later operations keep filling the open bundle. The held operation becomes slot 0 of the very next bundle.
- R5: The open bundle closes when it is full. It also closes when the incoming operation depends on the held operation, or depends on the open bundle while another operation is already held. That incoming operation is not accepted until after the close.
- R6: A slot with no operation is a no-op: its valid bit is 0 and its id is 0.
- R7: `flush` high with `in_valid` low closes a non-empty open bundle. A held operation is emitted in the bundle after it. An empty packer emits nothing on flush.
- R8: While `out_valid`=1 and `out_ready`=0, the output bundle stays unchanged. Every accepted operation is emitted exactly once, in bundle order.
- R9: After reset `out_valid` is 0, and an operation without a dependency is ready to be accepted.
- R10: For ids a..o with a dependency of c on b, f on e and g on f, the bundles are abde, cfhi, gjkl, mno. If l also depends on k, the last two become gjkm and lno.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the input |
| in_ready | output | 1 | Packer takes the operation this cycle |
| in_id | input | ID_W | Operation identifier |
| in_dep_valid | input | 1 | Operation consumes a producer's result |
| in_dep_id | input | ID_W | Identifier of the producer |
| flush | input | 1 | End of stream: emit the partial bundle |
| out_valid | output | 1 | Bundle present on the output |
| out_ready | input | 1 | Consumer takes the bundle |
| out_slot_valid | output | SLOTS | Per-slot operation present (0 = no-op) |
| out_slot_id | output | SLOTS*ID_W | Per-slot operation id, slot i at bits i*ID_W |

## Verification
The packer is driven with several stream shapes. A fully independent stream shows that bundles close only when full. The mixed-dependency stream, once without and once with the extra k-to-l edge, shows that deferral moves exactly one operation by one bundle. A pure chain must give one operation per bundle. A stream with two consumers of the same producer makes the second conflict force an early close. A stream whose dependency flag is clear while its producer id matches shows that the flag, not the id, decides. The independent stream is repeated with a stalling consumer, so any loss, duplication or change under backpressure shows up against the scoreboard.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

  // Width of a counter that must reach n inclusive.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // True when the set bits of m are a run starting at bit 0.
  function automatic logic low_run(input logic [31:0] m);
    return (m & (m + 32'd1)) == 32'd0;
  endfunction

endpackage

// File: rtl/vpk_hazard.sv
module vpk_hazard #(
  parameter int SLOTS = 4,
  parameter int ID_W  = 8
) (
  input  logic [SLOTS-1:0]           slot_v,
  input  logic [SLOTS-1:0][ID_W-1:0] slot_id,
  input  logic                       held_v,
  input  logic [ID_W-1:0]            held_id,
  input  logic                       dep_v,
  input  logic [ID_W-1:0]            dep_id,
  output logic                       hit_open,
  output logic                       hit_held
);
  logic [SLOTS-1:0] match;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign match[i] = slot_v[i] && (slot_id[i] == dep_id);
  end

  assign hit_open = dep_v && (|match);
  assign hit_held = dep_v && held_v && (held_id == dep_id);
endmodule

// File: rtl/vpk_ctrl.sv
module vpk_ctrl #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 3
) (
  input  logic             in_valid,
  input  logic             flush,
  input  logic [CNT_W-1:0] cnt,
  input  logic             held_v,
  input  logic             hit_open,
  input  logic             hit_held,
  input  logic             out_free,
  output logic             in_ready,
  output logic             place_ev,
  output logic             hold_ev,
  output logic             close_ev
);
  logic acc_full, acc_empty, last_free, can_place, can_hold;

  assign acc_full  = (cnt == CNT_W'(SLOTS));
  assign acc_empty = (cnt == '0);
  assign last_free = (cnt == CNT_W'(SLOTS - 1));
  assign can_place = !hit_open && !hit_held;
  assign can_hold  = hit_open && !hit_held && !held_v;
  assign in_ready  = !acc_full && (can_place || can_hold);

  always_comb begin
    place_ev = 1'b0;
    hold_ev  = 1'b0;
    close_ev = 1'b0;
    if (acc_full) begin
      close_ev = out_free;
    end else if (in_valid) begin
      if (can_place) begin
        place_ev = 1'b1;
        close_ev = last_free && out_free;
      end else if (can_hold) begin
        hold_ev = 1'b1;
      end else begin
        close_ev = out_free;
      end
    end else if (flush) begin
      close_ev = out_free && !acc_empty;
    end
  end
endmodule

// File: rtl/vpk_slots.sv
module vpk_slots #(
  parameter int SLOTS = 4,
  parameter int ID_W  = 8,
  parameter int CNT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       place_ev,
  input  logic                       hold_ev,
  input  logic                       close_ev,
  input  logic                       out_free,
  input  logic [ID_W-1:0]            in_id,
  output logic [SLOTS-1:0]           slot_v,
  output logic [SLOTS-1:0][ID_W-1:0] slot_id,
  output logic [CNT_W-1:0]           cnt,
  output logic                       held_v,
  output logic [ID_W-1:0]            held_id,
  output logic [SLOTS-1:0]           bundle_v,
  output logic [SLOTS-1:0][ID_W-1:0] bundle_id
);
  // Bundle as it stands after this cycle's placement, if any.
  for (genvar i = 0; i < SLOTS; i++) begin : g_merge
    logic here;
    assign here         = place_ev && (cnt == CNT_W'(i));
    assign bundle_v[i]  = slot_v[i] | here;
    assign bundle_id[i] = here ? in_id : slot_id[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v  <= '0;
      slot_id <= '0;
      cnt     <= '0;
      held_v  <= 1'b0;
      held_id <= '0;
    end else if (close_ev) begin
      slot_v     <= '0;
      slot_id    <= '0;
      slot_v[0]  <= held_v;
      slot_id[0] <= held_v ? held_id : '0;
      cnt        <= held_v ? CNT_W'(1) : '0;
      held_v     <= 1'b0;
      held_id    <= '0;
    end else begin
      if (place_ev) begin
        slot_v  <= bundle_v;
        slot_id <= bundle_id;
        cnt     <= cnt + CNT_W'(1);
      end
      if (hold_ev) begin
        held_v  <= 1'b1;
        held_id <= in_id;
      end
    end
  end

  AST_HELD_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    held_v |-> (cnt != '0)); // R4

  AST_HELD_LEADS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (close_ev && held_v) |=> (cnt == CNT_W'(1) && slot_v[0] && slot_id[0] == $past(held_id))); // R4

  AST_FULL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(SLOTS) && out_free) |=> (cnt != CNT_W'(SLOTS))); // R5
endmodule

// File: rtl/vpk_outreg.sv
module vpk_outreg #(
  parameter int SLOTS = 4,
  parameter int ID_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [SLOTS-1:0]           bundle_v,
  input  logic [SLOTS-1:0][ID_W-1:0] bundle_id,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [SLOTS-1:0]           out_v,
  output logic [SLOTS-1:0][ID_W-1:0] out_id,
  output logic                       out_free
);
  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_v     <= '0;
      out_id    <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_v     <= bundle_v;
      out_id    <= bundle_id;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_v) && $stable(out_id))); // R8

  AST_SLOT0_USED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_v[0]); // R1

  AST_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> vpk_pkg::low_run(32'(out_v))); // R1

  for (genvar i = 0; i < SLOTS; i++) begin : g_noop
    AST_NOOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_v[i]) |-> (out_id[i] == '0)); // R6
  end
endmodule

// File: rtl/vliw_packer.sv
module vliw_packer #(
  parameter int SLOTS = 4,
  parameter int ID_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ID_W-1:0]         in_id,
  input  logic                    in_dep_valid,
  input  logic [ID_W-1:0]         in_dep_id,
  input  logic                    flush,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SLOTS-1:0]        out_slot_valid,
  output logic [SLOTS*ID_W-1:0]   out_slot_id
);
  localparam int CNT_W = vpk_pkg::cnt_bits(SLOTS);

  logic [SLOTS-1:0]           slot_v, bundle_v, o_v;
  logic [SLOTS-1:0][ID_W-1:0] slot_id, bundle_id, o_id;
  logic [CNT_W-1:0]           cnt;
  logic                       held_v, hit_open, hit_held, out_free;
  logic [ID_W-1:0]            held_id;
  logic                       place_ev, hold_ev, close_ev;

  vpk_hazard #(.SLOTS(SLOTS), .ID_W(ID_W)) u_hazard (
    .slot_v(slot_v), .slot_id(slot_id), .held_v(held_v), .held_id(held_id),
    .dep_v(in_dep_valid), .dep_id(in_dep_id),
    .hit_open(hit_open), .hit_held(hit_held)
  );

  vpk_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_ctrl (
    .in_valid(in_valid), .flush(flush), .cnt(cnt), .held_v(held_v),
    .hit_open(hit_open), .hit_held(hit_held), .out_free(out_free),
    .in_ready(in_ready), .place_ev(place_ev), .hold_ev(hold_ev), .close_ev(close_ev)
  );

  vpk_slots #(.SLOTS(SLOTS), .ID_W(ID_W), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .place_ev(place_ev), .hold_ev(hold_ev),
    .close_ev(close_ev), .out_free(out_free), .in_id(in_id),
    .slot_v(slot_v), .slot_id(slot_id), .cnt(cnt), .held_v(held_v), .held_id(held_id),
    .bundle_v(bundle_v), .bundle_id(bundle_id)
  );

  vpk_outreg #(.SLOTS(SLOTS), .ID_W(ID_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(close_ev), .bundle_v(bundle_v), .bundle_id(bundle_id),
    .out_ready(out_ready), .out_valid(out_valid), .out_v(o_v), .out_id(o_id),
    .out_free(out_free)
  );

  assign out_slot_valid = o_v;
  assign out_slot_id    = o_id;

  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(SLOTS)) |-> !in_ready); // R1
endmodule

// File: tb/tb_vliw_packer.sv
module tb_vliw_packer;
  localparam int SLOTS = 4;
  localparam int ID_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_dep_valid = 1'b0, flush = 1'b0, out_ready = 1'b1;
  logic [ID_W-1:0] in_id = '0, in_dep_id = '0;
  logic in_ready, out_valid;
  logic [SLOTS-1:0] out_slot_valid;
  logic [SLOTS*ID_W-1:0] out_slot_id;

  int checks = 0, failures = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  int          q_n[$];
  logic [31:0] q_ids[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  vliw_packer #(.SLOTS(SLOTS), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_dep_valid(in_dep_valid), .in_dep_id(in_dep_id),
    .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot_valid(out_slot_valid), .out_slot_id(out_slot_id)
  );

  // Consumer readiness pattern, changed away from the active edge.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= !stall_mode || ((cyc % 3) != 0);
  end

  task automatic expect_b(input int n, input int a0, input int a1, input int a2, input int a3,
                          input string tag);
    logic [31:0] p;
    p = {8'(a3), 8'(a2), 8'(a1), 8'(a0)};
    q_n.push_back(n);
    q_ids.push_back(p);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares each transferred bundle with the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && out_valid && out_ready) begin
        checks++;
        if (q_n.size() == 0) begin
          failures++;
          $display("FAIL R7 unexpected bundle valid=%b ids=%h expected none",
                   out_slot_valid, out_slot_id);
        end else begin
          int n;
          logic [31:0] ids;
          logic [3:0] ev;
          string tag;
          n = q_n.pop_front();
          ids = q_ids.pop_front();
          tag = q_tag.pop_front();
          ev = 4'((1 << n) - 1);
          for (int i = n; i < SLOTS; i++) ids[i*8 +: 8] = 8'd0;
          if (out_slot_valid !== ev || out_slot_id !== ids) begin
            failures++;
            $display("FAIL %s bundle valid=%b ids=%h expected valid=%b ids=%h",
                     tag, out_slot_valid, out_slot_id, ev, ids);
          end
        end
      end
    end
  end

  task automatic send(input int id, input bit dv, input int did);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_id = ID_W'(id);
    in_dep_valid = dv;
    in_dep_id = ID_W'(did);
    ok = 1'b0;
    while (!ok) begin
      #4;
      ok = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_dep_valid = 1'b0;
    in_dep_id = '0;
  endtask

  task automatic drain();
    @(negedge clk);
    flush = 1'b1;
    for (int k = 0; k < 60 && q_n.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    flush = 1'b0;
  endtask

  // Fifteen ops a..o with ids base..base+14.
  task automatic run_alpha(input int base, input bit kl);
    for (int i = 0; i < 15; i++) begin
      bit dv;
      int did;
      dv = 1'b0;
      did = 0;
      if (i == 2) begin dv = 1'b1; did = base + 1; end
      if (i == 5) begin dv = 1'b1; did = base + 4; end
      if (i == 6) begin dv = 1'b1; did = base + 5; end
      if (kl && i == 11) begin dv = 1'b1; did = base + 10; end
      send(base + i, dv, did);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R9 out_valid=%b expected 0", out_valid);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R9 in_ready=%b expected 1", in_ready);
    end

    // R10 R3 R4: mixed stream a..o = 1..15
    expect_b(4, 1, 2, 4, 5, "R10");
    expect_b(4, 3, 6, 8, 9, "R4");
    expect_b(4, 7, 10, 11, 12, "R3");
    expect_b(3, 13, 14, 15, 0, "R10");
    run_alpha(1, 1'b0);
    drain();

    // R10 R2: same stream with l depending on k
    expect_b(4, 1, 2, 4, 5, "R10");
    expect_b(4, 3, 6, 8, 9, "R10");
    expect_b(4, 7, 10, 11, 13, "R2");
    expect_b(3, 12, 14, 15, 0, "R4");
    run_alpha(1, 1'b1);
    drain();

    // R5 R6 R7: pure chain, one op per bundle, remaining slots no-ops
    expect_b(1, 20, 0, 0, 0, "R5");
    expect_b(1, 21, 0, 0, 0, "R6");
    expect_b(1, 22, 0, 0, 0, "R7");
    expect_b(1, 23, 0, 0, 0, "R7");
    send(20, 0, 0);
    send(21, 1, 20);
    send(22, 1, 21);
    send(23, 1, 22);
    drain();

    // R5: second conflict while one op is held forces an early close
    expect_b(1, 30, 0, 0, 0, "R5");
    expect_b(3, 31, 32, 33, 0, "R5");
    send(30, 0, 0);
    send(31, 1, 30);
    send(32, 1, 30);
    send(33, 0, 0);
    drain();

    // R2: dependency flag clear means the matching id is ignored
    expect_b(4, 70, 71, 72, 73, "R2");
    send(70, 0, 0);
    send(71, 0, 70);
    send(72, 0, 71);
    send(73, 0, 72);
    drain();

    // R7: flush on an empty packer emits nothing (monitor flags any bundle)
    drain();

    // R8 R1: independent stream under a stalling consumer
    stall_mode = 1'b1;
    expect_b(4, 40, 41, 42, 43, "R8");
    expect_b(4, 44, 45, 46, 47, "R1");
    expect_b(4, 48, 49, 50, 51, "R8");
    for (int i = 40; i < 52; i++) send(i, 0, 0);
    drain();
    stall_mode = 1'b0;

    // R8 R4: mixed stream under stall
    stall_mode = 1'b1;
    expect_b(4, 101, 102, 104, 105, "R8");
    expect_b(4, 103, 106, 108, 109, "R8");
    expect_b(4, 107, 110, 111, 113, "R8");
    expect_b(3, 112, 114, 115, 0, "R8");
    run_alpha(101, 1'b1);
    drain();
    stall_mode = 1'b0;

    repeat (5) @(negedge clk);
    checks++;
    if (q_n.size() != 0) begin
      failures++;
      $display("FAIL R8 bundles missing=%0d expected 0", q_n.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired pending=%0d expected 0", q_n.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule